// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block turns an 8-bit sample code into the registered switch controls of a segmented current-steering converter. The code is split into two parts. The low two bits are binary weighted and drive their cells straight through, with no decode. The upper six bits form a thermometer segment. That segment is decoded into 63 equal unit cells, and each unit cell carries four LSBs of weight. The decode uses row and column selection over an 8x8 cell matrix. Every control leaves the block as a pair of flops, one for each side, so that each cell steers its current to the positive or the negative output.

A compile-time stride sets a fixed scramble. The stride assigns logical thermometer positions to physical cells at the latch outputs, which spreads gradient error across the array. The default stride of 1 keeps the natural order.

The sample path takes a valid strobe and has no ready. The block accepts every strobed code, so there is never back-pressure. A cycle without the strobe leaves the latched controls where they are.

Top module: `sdac_switch_decoder`

## Requirements
- R1: `in_code[7:2]` is the thermometer value and `in_code[1:0]` is the binary value. A change in bit 2 moves exactly one unit cell, and a change in bits 1:0 moves no unit cell.
- R2: After a code is accepted, the number of asserted `therm_p` bits equals the accepted `in_code[7:2]`.
- R3: With stride 1, logical cell `i = r*8 + c` is on when `r < in_code[7:5]`, or when `r == in_code[7:5]` and `c < in_code[4:2]`. Matrix position (7,7) is unused. As a result, `therm_p[i]` is 1 exactly when `i < in_code[7:2]`.
- R4: `bin_p[1]` equals the accepted `in_code[1]` (the 2-LSB cell) and `bin_p[0]` equals the accepted `in_code[0]` (the 1-LSB cell).
- R5: In every cycle, `therm_n` is the bitwise inverse of `therm_p` and `bin_n` is the bitwise inverse of `bin_p`.
- R6: A code sampled with `in_valid` high on a rising edge shows at the outputs right after that edge, and not before it.
- R7: While `in_valid` is low, every output holds its value, whatever `in_code` does.
- R8: A synchronous active-low reset drives every `_p` output to 0 and every `_n` output to 1, which is the code-0 state.
- R9: With stride S, where S is coprime to 63, logical cell `i` drives physical output `(i*S) mod 63`.
- R10: 4 × (count of `therm_p` ones) + 2 × `bin_p[1]` + `bin_p[0]` equals the last accepted code, for any stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Code strobe; the code is latched when this is high |
| in_code | input | 8 | Sample code |
| therm_p | output | 63 | Unit-cell controls, steer to positive output |
| therm_n | output | 63 | Unit-cell controls, steer to negative output |
| bin_p | output | 2 | Binary-cell controls, positive side (bit 1 = 2 LSB) |
| bin_n | output | 2 | Binary-cell controls, negative side |

## Verification
A wrong row or column compare inside the matrix decode shows on the cycle right after the code is accepted. It appears either as a unit-cell count that differs from the top six bits, or as a hole in the otherwise solid run of ones. A scramble that is not a bijection loses or duplicates a cell, so the weighted sum misses the code on the first affected value. A pair flop that drifts from its partner breaks the complement in that same cycle. The sweeps cover the low-end steps, the mid-scale steps and all 256 codes, with both the natural order and a scrambled order.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Physical slot for a logical thermometer index under a stride scramble.
  function automatic int unsigned slot_of(input int unsigned idx,
                                          input int unsigned stride,
                                          input int unsigned cells);
    return (idx * stride) % cells;
  endfunction
endpackage

// File: rtl/sdac_rowcol_dec.sv
module sdac_rowcol_dec #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  localparam int SEG_W   = ROW_BITS + COL_BITS,
  localparam int N_ROWS  = 1 << ROW_BITS,
  localparam int N_COLS  = 1 << COL_BITS,
  localparam int N_CELLS = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0]   seg,
  output logic [N_CELLS-1:0] cell_on
);
  logic [ROW_BITS-1:0] row_sel;
  logic [COL_BITS-1:0] col_sel;
  logic [N_ROWS-1:0]   row_full;
  logic [N_ROWS-1:0]   row_part;
  logic [N_COLS-1:0]   col_low;

  assign row_sel = seg[SEG_W-1:COL_BITS];
  assign col_sel = seg[COL_BITS-1:0];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign row_full[r] = (row_sel >  ROW_BITS'(r));
    assign row_part[r] = (row_sel == ROW_BITS'(r));
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    assign col_low[c] = (col_sel > COL_BITS'(c));
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_mr
    for (genvar c = 0; c < N_COLS; c++) begin : g_mc
      if (r * N_COLS + c < N_CELLS) begin : g_cell
        assign cell_on[r*N_COLS+c] = row_full[r] | (row_part[r] & col_low[c]);
      end
    end
  end
endmodule

// File: rtl/sdac_cell_map.sv
module sdac_cell_map #(
  parameter int N_CELLS = 63,
  parameter int STRIDE  = 1
) (
  input  logic [N_CELLS-1:0] logical,
  output logic [N_CELLS-1:0] physical
);
  import sdac_pkg::*;

  if (STRIDE == 1) begin : g_ident
    assign physical = logical;
  end else begin : g_scram
    for (genvar i = 0; i < N_CELLS; i++) begin : g_idx
      localparam int SLOT = int'(slot_of(i, STRIDE, N_CELLS));
      assign physical[SLOT] = logical[i];
    end
  end
endmodule

// File: rtl/sdac_pair_latch.sv
module sdac_pair_latch #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_p,
  output logic [W-1:0] q_n
);
  // Two separate flops per cell so each side has its own driver.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_p <= '0;
      q_n <= '1;
    end else if (load) begin
      q_p <= d;
      q_n <= ~d;
    end
  end
endmodule

// File: rtl/sdac_switch_decoder.sv
module sdac_switch_decoder #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int BIN_BITS = 2,
  parameter int STRIDE   = 1,
  localparam int SEG_W   = ROW_BITS + COL_BITS,
  localparam int CODE_W  = SEG_W + BIN_BITS,
  localparam int N_CELLS = (1 << SEG_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CODE_W-1:0]  in_code,
  output logic [N_CELLS-1:0] therm_p,
  output logic [N_CELLS-1:0] therm_n,
  output logic [BIN_BITS-1:0] bin_p,
  output logic [BIN_BITS-1:0] bin_n
);
  logic [N_CELLS-1:0] cells_logical;
  logic [N_CELLS-1:0] cells_physical;

  sdac_rowcol_dec #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS)
  ) u_dec (
    .seg     (in_code[CODE_W-1:BIN_BITS]),
    .cell_on (cells_logical)
  );

  sdac_cell_map #(
    .N_CELLS(N_CELLS),
    .STRIDE (STRIDE)
  ) u_map (
    .logical  (cells_logical),
    .physical (cells_physical)
  );

  sdac_pair_latch #(.W(N_CELLS)) u_therm_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (cells_physical),
    .q_p   (therm_p),
    .q_n   (therm_n)
  );

  // Binary segment: straight from the code bits, no decode.
  sdac_pair_latch #(.W(BIN_BITS)) u_bin_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (in_code[BIN_BITS-1:0]),
    .q_p   (bin_p),
    .q_n   (bin_n)
  );
endmodule

// File: rtl/sdac_switch_decoder_chk.sv
module sdac_switch_decoder_chk #(
  parameter int SEG_W    = 6,
  parameter int BIN_BITS = 2,
  parameter int STRIDE   = 1,
  localparam int CODE_W  = SEG_W + BIN_BITS,
  localparam int N_CELLS = (1 << SEG_W) - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [CODE_W-1:0]  in_code,
  input logic [N_CELLS-1:0] therm_p,
  input logic [N_CELLS-1:0] therm_n,
  input logic [BIN_BITS-1:0] bin_p,
  input logic [BIN_BITS-1:0] bin_n
);
  p_pair_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_p ^ therm_n) == '1) && ((bin_p ^ bin_n) == '1));

  p_reset_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (therm_p == '0) && (bin_p == '0));

  p_cell_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |->
      (int'($countones(therm_p)) == int'($past(in_code[CODE_W-1:BIN_BITS]))));

  p_weight_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |->
      (int'($countones(therm_p)) * (2 ** BIN_BITS) + int'(bin_p)
        == int'($past(in_code))));

  p_bin_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |-> (bin_p == $past(in_code[BIN_BITS-1:0])));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(therm_p) && $stable(bin_p)));

  if (STRIDE == 1) begin : g_shape
    p_solid_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((therm_p + 1'b1) & therm_p) == '0);
  end
endmodule

bind sdac_switch_decoder sdac_switch_decoder_chk #(
  .SEG_W   (SEG_W),
  .BIN_BITS(BIN_BITS),
  .STRIDE  (STRIDE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_code  (in_code),
  .therm_p  (therm_p),
  .therm_n  (therm_n),
  .bin_p    (bin_p),
  .bin_n    (bin_n)
);

// File: tb/sim_sdac_switch_decoder.sv
module sim_sdac_switch_decoder;
  localparam int NC = 63;
  localparam int SCR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_code = '0;
  logic [NC-1:0] a_p, a_n, b_p, b_n;
  logic [1:0] ab_p, ab_n, bb_p, bb_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdac_switch_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .therm_p(a_p), .therm_n(a_n), .bin_p(ab_p), .bin_n(ab_n));

  sdac_switch_decoder #(.STRIDE(SCR)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .therm_p(b_p), .therm_n(b_n), .bin_p(bb_p), .bin_n(bb_n));

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_cells(input int m, input int stride);
    logic [NC-1:0] r = '0;
    for (int i = 0; i < NC; i++) if (i < m) r[(i * stride) % NC] = 1'b1;
    return r;
  endfunction

  task automatic check_code(input int code, input string tag);
    int m = code / 4;
    chk(a_p == exp_cells(m, 1), {tag, " R3 R1 natural order"}, 64'(a_p), 64'(exp_cells(m, 1)));
    chk(b_p == exp_cells(m, SCR), {tag, " R9 scrambled order"}, 64'(b_p), 64'(exp_cells(m, SCR)));
    chk($countones(b_p) == m, {tag, " R2 cell count"}, 64'($countones(b_p)), 64'(m));
    chk(ab_p == 2'(code % 4) && bb_p == 2'(code % 4), {tag, " R4 binary cells"},
        64'({ab_p, bb_p}), 64'({2'(code % 4), 2'(code % 4)}));
    chk(a_n == ~a_p && b_n == ~b_p && ab_n == ~ab_p && bb_n == ~bb_p,
        {tag, " R5 complement"}, 64'(a_n), 64'(~a_p));
    chk(4 * $countones(b_p) + 2 * int'(bb_p[1]) + int'(bb_p[0]) == code,
        {tag, " R10 weighted sum"},
        64'(4 * $countones(b_p) + 2 * int'(bb_p[1]) + int'(bb_p[0])), 64'(code));
  endtask

  task automatic apply(input int code, input string tag);
    @(negedge clk);
    in_code = 8'(code);
    in_valid = 1'b1;
    @(negedge clk);
    check_code(code, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(a_p == '0 && b_p == '0 && ab_p == '0, "R8 reset p side", 64'(a_p), 64'(0));
    chk(a_n == '1 && b_n == '1 && ab_n == 2'b11, "R8 reset n side", 64'(a_n), 64'({NC{1'b1}}));
    rst_n = 1'b1;

    // low-end stepping
    for (int k = 0; k <= 4; k++) apply(k, "low");
    // mid-scale stepping
    for (int k = 128; k <= 132; k++) apply(k, "mid");

    // R6: latency -- before the edge the old value remains
    @(negedge clk);
    in_code = 8'h55;
    in_valid = 1'b1;
    #1;
    chk(a_p == exp_cells(132 / 4, 1), "R6 not before edge", 64'(a_p), 64'(exp_cells(33, 1)));
    @(negedge clk);
    chk(a_p == exp_cells(8'h55 / 4, 1), "R6 after one edge", 64'(a_p), 64'(exp_cells(21, 1)));

    // R7: hold while strobe low
    @(negedge clk);
    in_valid = 1'b0;
    in_code = 8'hFF;
    repeat (3) @(negedge clk);
    check_code(8'h55, "R7 hold");
    in_code = 8'h00;
    @(negedge clk);
    check_code(8'h55, "R7 hold zero");

    // full sweep, up then a few jumps
    for (int k = 0; k < 256; k++) apply(k, "sweep");
    apply(255, "full");
    apply(0, "zero");
    apply(252, "R1 top");
    apply(3, "R1 bits");

    // R8: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_code = 8'hC7;
    @(negedge clk);
    chk(a_p == '0 && bb_p == '0, "R8 mid-run reset", 64'(a_p), 64'(0));
    chk(b_n == '1 && ab_n == 2'b11, "R8 mid-run reset n", 64'(b_n), 64'({NC{1'b1}}));
    rst_n = 1'b1;
    @(negedge clk);
    check_code(8'hC7, "after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule